// File: doc/BRIEF.md
# Unpacked Decimal Multiply/Divide Adjust Unit

This unit carries out the two adjustment steps used around unpacked-decimal multiplication and division. The 16-bit accumulator pair is split into a high byte and a low byte, and an 8-bit immediate base is supplied with each request. The split operation comes after a multiply. It divides the low byte by the base and places the quotient in the high byte and the remainder in the low byte. The fold operation comes before a divide. It forms the high byte times the base plus the low byte, keeps only eight bits of that sum, and clears the high byte.

A request is a one-cycle start pulse with an operation select, the accumulator and the base. A fold finishes on the first clock edge. A split runs a restoring shift-subtract divider that produces one quotient bit per clock, with busy held high while it runs. A split with a zero base does not write the result. It returns a fault together with the done pulse, and whoever issued the request decides how to handle the fault.

Both operations set flags as a logic operation would on the new low byte. Carry, auxiliary carry and overflow read zero. Sign, zero and parity come from the low byte. The base may be any 8-bit value.

Top module: `bcd_mdadj`

## Requirements
- R1: With op_sel_i=1 (fold), the result is {8'h00, (acc_i[15:8]*base_i + acc_i[7:0]) mod 256}. done_o is high in the cycle after the start edge, and busy_o never rises.
- R2: With op_sel_i=0 (split) and a nonzero base, result_o[15:8] = acc_i[7:0] / base_i and result_o[7:0] = acc_i[7:0] mod base_i. The incoming high byte has no effect.
- R3: A split with base_i=0 raises fault_o and done_o together in the cycle after the start edge. result_o and flags_o keep their previous values.
- R4: Flag positions are as follows. Bit 0 is carry, bit 1 is parity, bit 2 is auxiliary carry, bit 3 is zero, bit 4 is sign and bit 5 is overflow. After any successful operation, carry, auxiliary carry and overflow are 0. Parity is 1 when result_o[7:0] has an even number of ones. Zero is 1 when result_o[7:0] is 0. Sign equals result_o[7].
- R5: A split with a nonzero base holds busy_o high for exactly 8 cycles after the start edge. done_o pulses in the first cycle after that, with busy_o low.
- R6: A start pulse that arrives while busy_o is high is ignored. No extra done_o pulse follows it, and it does not change the result.
- R7: done_o lasts one cycle for each accepted request, and fault_o is high only together with done_o.
- R8: After reset, busy_o, done_o and fault_o are 0, and result_o and flags_o are all zeros.
- R9: A fold with base_i=0 does not fault and returns {8'h00, acc_i[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request pulse |
| op_sel_i | input | 1 | 0 = split (after multiply), 1 = fold (before divide) |
| acc_i | input | 16 | Accumulator pair, high byte in [15:8] |
| base_i | input | 8 | Immediate base |
| busy_o | output | 1 | Divider running |
| done_o | output | 1 | Result, flags or fault valid for one cycle |
| result_o | output | 16 | Adjusted accumulator pair |
| flags_o | output | 6 | Status flags, positions as in R4 |
| fault_o | output | 1 | Zero-base divide fault |

## Verification
The assertions assume that start_i is clean after reset and never X. They also assume that op_sel_i, acc_i and base_i only matter on the edge where start_i is accepted. On that basis, a rise of busy_o must always trace back to a start one cycle earlier. The stimulus changes inputs only on the falling edge and drops start_i after one cycle. It holds start_i high while busy only on purpose, to exercise R6. Each expected item is pushed into the scoreboard at the same time as the request is issued. The monitor pops one item per done_o pulse, so any extra or missing pulse shows up as a mismatch.

// File: rtl/bcdadj_pkg.sv
package bcdadj_pkg;
   typedef enum logic {OP_SPLIT = 1'b0, OP_FOLD = 1'b1} adj_op_e;
   typedef enum logic {ST_IDLE = 1'b0, ST_DIV = 1'b1} adj_state_e;
   localparam int FLAG_N   = 6;
   localparam int FL_CARRY = 0;
   localparam int FL_PAR   = 1;
   localparam int FL_AUX   = 2;
   localparam int FL_ZERO  = 3;
   localparam int FL_SIGN  = 4;
   localparam int FL_OVF   = 5;
endpackage

// File: rtl/bcdadj_divider.sv
module bcdadj_divider #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [DATA_W-1:0] dividend_i,
   input  logic [DATA_W-1:0] divisor_i,
   output logic              fin_o,
   output logic [DATA_W-1:0] quo_nx_o,
   output logic [DATA_W-1:0] rem_nx_o
);
   localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic              run_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] quo_q, rem_q, dvs_q;
   logic [DATA_W:0]   shifted, trial;
   logic              fits;

   always_comb begin
      shifted  = {rem_q, quo_q[DATA_W-1]};
      trial    = shifted - {1'b0, dvs_q};
      fits     = ~trial[DATA_W];
      rem_nx_o = fits ? trial[DATA_W-1:0] : shifted[DATA_W-1:0];
      quo_nx_o = {quo_q[DATA_W-2:0], fits};
      fin_o    = run_q && (cnt_q == LAST);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         cnt_q <= '0;
         quo_q <= '0;
         rem_q <= '0;
         dvs_q <= '0;
      end else if (load_i) begin
         run_q <= 1'b1;
         cnt_q <= '0;
         quo_q <= dividend_i;
         rem_q <= '0;
         dvs_q <= divisor_i;
      end else if (run_q) begin
         quo_q <= quo_nx_o;
         rem_q <= rem_nx_o;
         cnt_q <= cnt_q + CNT_W'(1);
         if (fin_o) run_q <= 1'b0;
      end
   end
endmodule

// File: rtl/bcdadj_fold.sv
module bcdadj_fold #(
   parameter int DATA_W = 8
) (
   input  logic [DATA_W-1:0] hi_i,
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] base_i,
   output logic [DATA_W-1:0] lo_o
);
   // Multiply-add in the byte width: the carry out is dropped on purpose
   always_comb lo_o = (hi_i * base_i) + lo_i;
endmodule

// File: rtl/bcdadj_flags.sv
module bcdadj_flags
   import bcdadj_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter bit PARITY_EVEN = 1'b1
) (
   input  logic [DATA_W-1:0] val_i,
   output logic [FLAG_N-1:0] flags_o
);
   logic par_bit;

   generate
      if (PARITY_EVEN) begin : g_par_even
         assign par_bit = ~^val_i;
      end else begin : g_par_odd
         assign par_bit = ^val_i;
      end
   endgenerate

   always_comb begin
      flags_o           = '0;
      flags_o[FL_PAR]   = par_bit;
      flags_o[FL_ZERO]  = (val_i == '0);
      flags_o[FL_SIGN]  = val_i[DATA_W-1];
   end
endmodule

// File: rtl/bcd_mdadj.sv
module bcd_mdadj
   import bcdadj_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter bit PARITY_EVEN = 1'b1,
   localparam int ACC_W      = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              op_sel_i,
   input  logic [ACC_W-1:0]  acc_i,
   input  logic [DATA_W-1:0] base_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ACC_W-1:0]  result_o,
   output logic [FLAG_N-1:0] flags_o,
   output logic              fault_o
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("bcd_mdadj: DATA_W must be at least 2");
      end
   endgenerate

   adj_state_e        state_q;
   logic [DATA_W-1:0] acc_hi, acc_lo;
   logic [DATA_W-1:0] fold_lo, quo_nx, rem_nx, flag_src;
   logic [FLAG_N-1:0] flag_nx;
   logic              accept, is_split, zero_base, div_load, div_fin;

   assign acc_hi    = acc_i[ACC_W-1:DATA_W];
   assign acc_lo    = acc_i[DATA_W-1:0];
   assign accept    = start_i && (state_q == ST_IDLE);
   assign is_split  = (adj_op_e'(op_sel_i) == OP_SPLIT);
   assign zero_base = (base_i == '0);
   assign div_load  = accept && is_split && !zero_base;
   assign flag_src  = (state_q == ST_DIV) ? rem_nx : fold_lo;
   assign busy_o    = (state_q == ST_DIV);

   bcdadj_divider #(.DATA_W(DATA_W)) div_u (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (div_load),
      .dividend_i (acc_lo),
      .divisor_i  (base_i),
      .fin_o      (div_fin),
      .quo_nx_o   (quo_nx),
      .rem_nx_o   (rem_nx)
   );

   bcdadj_fold #(.DATA_W(DATA_W)) fold_u (
      .hi_i   (acc_hi),
      .lo_i   (acc_lo),
      .base_i (base_i),
      .lo_o   (fold_lo)
   );

   bcdadj_flags #(.DATA_W(DATA_W), .PARITY_EVEN(PARITY_EVEN)) flg_u (
      .val_i   (flag_src),
      .flags_o (flag_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         done_o   <= 1'b0;
         fault_o  <= 1'b0;
         result_o <= '0;
         flags_o  <= '0;
      end else begin
         done_o  <= 1'b0;
         fault_o <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (!is_split) begin
                     result_o <= {{DATA_W{1'b0}}, fold_lo};
                     flags_o  <= flag_nx;
                     done_o   <= 1'b1;
                  end else if (zero_base) begin
                     done_o  <= 1'b1;
                     fault_o <= 1'b1;
                  end else begin
                     state_q <= ST_DIV;
                  end
               end
            end
            ST_DIV: begin
               if (div_fin) begin
                  result_o <= {quo_nx, rem_nx};
                  flags_o  <= flag_nx;
                  done_o   <= 1'b1;
                  state_q  <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bcd_mdadj_chk.sv
module bcd_mdadj_chk
   import bcdadj_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int ACC_W = 2 * DATA_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic [ACC_W-1:0]  result_o,
   input logic [FLAG_N-1:0] flags_o,
   input logic              fault_o
);
   // R7
   fault_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> done_o);

   // R5
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o);

   // R5
   busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));

   // R3
   fault_holds_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> ($stable(result_o) && $stable(flags_o)));

   // R4
   clear_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fault_o) |-> (!flags_o[FL_CARRY] && !flags_o[FL_AUX] && !flags_o[FL_OVF]));

   // R4
   zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fault_o) |-> (flags_o[FL_ZERO] == (result_o[DATA_W-1:0] == '0)));

   // R1
   fold_high_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !fault_o && !$past(busy_o)) |-> (result_o[ACC_W-1:DATA_W] == '0));
endmodule

bind bcd_mdadj bcd_mdadj_chk #(.DATA_W(DATA_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .busy_o   (busy_o),
   .done_o   (done_o),
   .result_o (result_o),
   .flags_o  (flags_o),
   .fault_o  (fault_o)
);

// File: tb/bcd_mdadj_tb_top.sv
`timescale 1ns/1ps
module bcd_mdadj_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        op_sel_i = 1'b0;
   logic [15:0] acc_i = '0;
   logic [7:0]  base_i = '0;
   logic        busy_o, done_o, fault_o;
   logic [15:0] result_o;
   logic [5:0]  flags_o;

   typedef struct {
      logic [15:0] res;
      logic [5:0]  flg;
      logic        flt;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          checks = 0;
   int          errors = 0;
   int          dones  = 0;
   logic [15:0] mdl_res = '0;
   logic [5:0]  mdl_flg = '0;
   bit          finished = 1'b0;

   always #2 clk = ~clk;

   bcd_mdadj dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sel_i(op_sel_i),
      .acc_i(acc_i), .base_i(base_i), .busy_o(busy_o), .done_o(done_o),
      .result_o(result_o), .flags_o(flags_o), .fault_o(fault_o)
   );

   function automatic logic [5:0] mk_flags(input logic [7:0] v);
      logic [5:0] f;
      f = '0;
      f[1] = ~^v;
      f[3] = (v == 8'h00);
      f[4] = v[7];
      return f;
   endfunction

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // Monitor: one scoreboard item per done pulse
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         dones++;
         if (sb_q.size() == 0) begin
            check(1'b0, "R7", "unexpected done", 32'(result_o), 32'hx);
         end else begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (result_o !== e.res || flags_o !== e.flg || fault_o !== e.flt) begin
               errors++;
               $display("FAIL %s result %h exp %h flags %b exp %b fault %b exp %b",
                        e.tag, result_o, e.res, flags_o, e.flg, fault_o, e.flt);
            end
         end
      end
   end

   task automatic push_exp(input bit op, input logic [15:0] acc,
                           input logic [7:0] base, input string tag);
      exp_t e;
      logic [7:0] lo;
      e.tag = tag;
      if (op) begin
         lo = 8'((int'(acc[15:8]) * int'(base) + int'(acc[7:0])) % 256);
         e.res = {8'h00, lo}; e.flg = mk_flags(lo); e.flt = 1'b0;
      end else if (base == 8'h00) begin
         e.res = mdl_res; e.flg = mdl_flg; e.flt = 1'b1;
      end else begin
         e.res = {acc[7:0] / base, acc[7:0] % base};
         e.flg = mk_flags(e.res[7:0]); e.flt = 1'b0;
      end
      mdl_res = e.res; mdl_flg = e.flg;
      sb_q.push_back(e);
   endtask

   // Driver: issue one request and check its timing
   task automatic do_op(input bit op, input logic [15:0] acc,
                        input logic [7:0] base, input string tag);
      int n;
      while (busy_o) @(negedge clk);
      start_i = 1'b1; op_sel_i = op; acc_i = acc; base_i = base;
      push_exp(op, acc, base, tag);
      @(negedge clk);
      start_i = 1'b0;
      if (!op && base != 8'h00) begin
         n = 0;
         while (busy_o && n < 20) begin n++; @(negedge clk); end
         check(n == 8, "R5", "busy cycles", 32'(n), 32'd8);
         check(done_o == 1'b1, "R5", "done after busy", 32'(done_o), 32'd1);
      end else begin
         check(!busy_o && done_o, tag, "single-cycle done", {busy_o, done_o}, 32'b01);
      end
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int d0;
      repeat (3) @(negedge clk);
      // R8 reset state
      check(!busy_o && !done_o && !fault_o, "R8", "status", {busy_o, done_o, fault_o}, 0);
      check(result_o == 16'h0 && flags_o == 6'h0, "R8", "data", {result_o, 10'(flags_o)}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      do_op(1'b1, 16'h0705, 8'd10,  "R1");
      do_op(1'b1, 16'h1909, 8'h10,  "R1");
      do_op(1'b1, 16'hFFFF, 8'hFF,  "R4");
      do_op(1'b1, 16'h3300, 8'h00,  "R9");
      do_op(1'b0, 16'hAA4B, 8'd10,  "R2");
      do_op(1'b0, 16'h00FF, 8'h07,  "R2");
      do_op(1'b0, 16'h1280, 8'h01,  "R4");
      do_op(1'b0, 16'h55FF, 8'hFF,  "R2");
      do_op(1'b0, 16'h0005, 8'd200, "R2");
      do_op(1'b0, 16'h1234, 8'h00,  "R3");
      do_op(1'b0, 16'h1200, 8'h03,  "R4");

      // R6: a start during busy is ignored
      d0 = dones;
      start_i = 1'b1; op_sel_i = 1'b0; acc_i = 16'h0063; base_i = 8'd10;
      push_exp(1'b0, 16'h0063, 8'd10, "R6");
      @(negedge clk);
      op_sel_i = 1'b1; acc_i = 16'h0101; base_i = 8'h02;
      @(negedge clk);
      start_i = 1'b0;
      repeat (14) @(negedge clk);
      check(dones - d0 == 1, "R6", "done count", 32'(dones - d0), 32'd1);
      check(result_o == 16'h0909, "R6", "result kept", 32'(result_o), 32'h0909);

      // R7 and mixed patterns
      for (int i = 0; i < 24; i++) begin
         logic [15:0] a;
         logic [7:0]  b;
         a = 16'((i * 40503 + 977) & 16'hFFFF);
         b = 8'((i * 37 + 3) & 8'hFF);
         if (i % 7 == 5) b = 8'h00;
         do_op(i[0], a, b, i[0] ? "R1" : (b == 8'h00 ? "R3" : "R2"));
      end

      repeat (4) @(negedge clk);
      check(sb_q.size() == 0, "R7", "pending items", 32'(sb_q.size()), 32'd0);
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule